// File: doc/BRIEF.md
# Oversampled Manchester Receive Decoder

This block recovers the bit stream from a Manchester-coded serial line that runs at one sixteenth of the local sampling clock (a 10 Mbps line sampled at 160 MHz). The asynchronous line is passed through a short synchronizer chain. The transition that Manchester coding guarantees in the middle of every bit is then used as the only timing reference. Each accepted mid-bit transition restarts a sample counter. Transitions that arrive too soon after it are treated as optional bit-boundary edges and are discarded. Because timing is re-centred on every bit, a transmitter running slightly fast or slow cannot make the receiver gain or lose bits, even over a frame of more than twelve thousand bits.

The direction of each accepted transition is the decoded bit. A run of alternating bits acquires lock. The first pair of equal ones that follows the run marks the start of the frame. Every bit after that pair is delivered with a one-cycle strobe. When the line stays quiet for one and a half bit periods, the block reports the end of the frame and starts hunting for a new preamble.

Top module: `mrxReceiver`

## Requirements
- R1: While reset is held and in the first cycle after its release, `bitValid`, `frameStart`, `frameEnd` and `locked` are all low.
- R2: A low-to-high mid-bit transition decodes as `bitData` = 1 and a high-to-low one as 0. The line is low then high for a 1, and high then low for a 0.
- R3: After an accepted transition, any transition within the next 11 samples (BLANK = 3/4 of SAMPLES_PER_BIT = 12) is ignored. Payloads of all ones and all zeros, which toggle at every bit boundary, decode without error.
- R4: The bit timer restarts on every accepted transition. Frames of 1500 bits sent with bit periods of 15 or 17 samples are delivered with exactly 1500 bits and no errors.
- R5: Lock needs a run of at least LOCK_BITS = 16 alternating bits, counting the first one of the closing pair. With a run of 15, no frame start and no bits are reported.
- R6: When a second consecutive 1 arrives while locked, `frameStart` pulses for one cycle. The two closing ones are not delivered as data, and every later bit of the frame is delivered with a one-cycle `bitValid`.
- R7: If no transition is accepted for LIMIT = 3/2 of SAMPLES_PER_BIT = 24 samples, a frame in progress ends with a single `frameEnd` pulse and the block returns to hunting. A transition exactly 24 samples after the last one is still accepted as a bit.
- R8: No two of `bitValid`, `frameStart` and `frameEnd` are ever high in the same cycle.
- R9: `locked` is high from lock acquisition until the frame ends or lock is lost, and is low after `frameEnd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, SAMPLES_PER_BIT cycles per line bit |
| rstN | input | 1 | Active-low synchronous reset |
| lineIn | input | 1 | Asynchronous Manchester-coded line |
| bitValid | output | 1 | One-cycle strobe for a decoded payload bit |
| bitData | output | 1 | Decoded bit value, meaningful while `bitValid` is high |
| frameStart | output | 1 | One-cycle pulse when the start-of-frame pair is seen |
| frameEnd | output | 1 | One-cycle pulse when a frame ends on line silence |
| locked | output | 1 | High while preamble lock is held or a frame is in progress |

## Verification
Bit decoding and silence detection can fall due in the same sample. This happens when a transition arrives exactly at the limit count, where the silence limit expires. The bench provokes it by stretching the last half-bit of a frame to exactly 24 samples and then to 25 samples before toggling the line once more. At 24 the late transition must win: it appears as one extra bit, with the opposite value to the last payload bit, before the single frame end. At 25 the frame must end first, and the stray transition must produce no data strobe.

// File: rtl/mrxPkg.sv
package mrxPkg;

  // Line events reported by the datapath each sample.
  typedef struct packed {
    logic edgeSeen;   // synchronized line changed this sample
    logic edgeRise;   // the change was low-to-high
    logic pastBlank;  // timer has left the blanking window
    logic atLimit;    // timer has reached the silence limit
  } lineEvt_t;

  // Strobes issued by the control to the datapath.
  typedef struct packed {
    logic restartTimer;  // an edge was accepted as a mid-bit edge
  } ctrlStrobe_t;

  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_LOCKED = 2'd1,
    ST_FRAME  = 2'd2
  } rxState_t;

endpackage

// File: rtl/mrxDatapath.sv
module mrxDatapath
  import mrxPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BLANK       = 12,
  parameter int LIMIT       = 24
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        lineIn,
  input  ctrlStrobe_t strobe,
  output lineEvt_t    evt
);

  localparam int TW = $clog2(LIMIT + 1);
  localparam logic [TW-1:0] LIMIT_V = TW'(LIMIT);
  localparam logic [TW-1:0] BLANK_V = TW'(BLANK);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   syncOut;
  logic                   lastLevel;
  logic [TW-1:0]          timer;

  // Synchronizer chain; the stage count picks the shape.
  if (SYNC_STAGES == 1) begin : g_syncSingle
    always_ff @(posedge clk) begin
      if (!rstN) syncChain <= '0;
      else       syncChain <= lineIn;
    end
  end else begin : g_syncChain
    always_ff @(posedge clk) begin
      if (!rstN) syncChain <= '0;
      else       syncChain <= {syncChain[SYNC_STAGES-2:0], lineIn};
    end
  end

  assign syncOut = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) lastLevel <= 1'b0;
    else       lastLevel <= syncOut;
  end

  // Samples since the last accepted edge, saturating at the limit.
  always_ff @(posedge clk) begin
    if (!rstN)                    timer <= LIMIT_V;
    else if (strobe.restartTimer) timer <= TW'(1);
    else if (timer != LIMIT_V)    timer <= timer + 1'b1;
  end

  always_comb begin
    evt.edgeSeen  = syncOut ^ lastLevel;
    evt.edgeRise  = syncOut & ~lastLevel;
    evt.pastBlank = (timer >= BLANK_V);
    evt.atLimit   = (timer == LIMIT_V);
  end

endmodule

// File: rtl/mrxControl.sv
module mrxControl
  import mrxPkg::*;
#(
  parameter int LOCK_BITS = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  lineEvt_t    evt,
  output ctrlStrobe_t strobe,
  output logic        bitValid,
  output logic        bitData,
  output logic        frameStart,
  output logic        frameEnd,
  output logic        locked
);

  localparam int RW = $clog2(LOCK_BITS + 1);
  localparam logic [RW-1:0] LOCK_V = RW'(LOCK_BITS);

  rxState_t      state;
  logic          prevBit;
  logic          havePrev;
  logic [RW-1:0] runLen;
  logic [RW-1:0] runNext;
  logic          accept;
  logic          newBit;
  logic          silent;

  always_comb begin
    accept = evt.edgeSeen && evt.pastBlank;
    newBit = evt.edgeRise;
    silent = evt.atLimit && !accept;
    if (havePrev && (newBit != prevBit))
      runNext = (runLen == LOCK_V) ? LOCK_V : runLen + 1'b1;
    else
      runNext = RW'(1);
    strobe.restartTimer = accept;
  end

  assign locked = (state != ST_HUNT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_HUNT;
      prevBit    <= 1'b0;
      havePrev   <= 1'b0;
      runLen     <= '0;
      bitValid   <= 1'b0;
      bitData    <= 1'b0;
      frameStart <= 1'b0;
      frameEnd   <= 1'b0;
    end else begin
      bitValid   <= 1'b0;
      frameStart <= 1'b0;
      frameEnd   <= 1'b0;
      if (accept) begin
        prevBit  <= newBit;
        havePrev <= 1'b1;
        runLen   <= runNext;
        unique case (state)
          ST_HUNT: begin
            if (runNext == LOCK_V) state <= ST_LOCKED;
          end
          ST_LOCKED: begin
            if (newBit == prevBit) begin
              if (newBit) begin
                state      <= ST_FRAME;
                frameStart <= 1'b1;
              end else begin
                state <= ST_HUNT;
              end
            end
          end
          ST_FRAME: begin
            bitValid <= 1'b1;
            bitData  <= newBit;
          end
          default: state <= ST_HUNT;
        endcase
      end else if (silent) begin
        havePrev <= 1'b0;
        runLen   <= '0;
        state    <= ST_HUNT;
        frameEnd <= (state == ST_FRAME);
      end
    end
  end

endmodule

// File: rtl/mrxReceiver.sv
module mrxReceiver
  import mrxPkg::*;
#(
  parameter int SAMPLES_PER_BIT = 16,
  parameter int SYNC_STAGES     = 2,
  parameter int LOCK_BITS       = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic bitValid,
  output logic bitData,
  output logic frameStart,
  output logic frameEnd,
  output logic locked
);

  localparam int BLANK = (SAMPLES_PER_BIT * 3) / 4;
  localparam int LIMIT = (SAMPLES_PER_BIT * 3) / 2;

  lineEvt_t    evt;
  ctrlStrobe_t strobe;

  mrxDatapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .BLANK      (BLANK),
    .LIMIT      (LIMIT)
  ) u_datapath (
    .clk   (clk),
    .rstN  (rstN),
    .lineIn(lineIn),
    .strobe(strobe),
    .evt   (evt)
  );

  mrxControl #(
    .LOCK_BITS(LOCK_BITS)
  ) u_control (
    .clk       (clk),
    .rstN      (rstN),
    .evt       (evt),
    .strobe    (strobe),
    .bitValid  (bitValid),
    .bitData   (bitData),
    .frameStart(frameStart),
    .frameEnd  (frameEnd),
    .locked    (locked)
  );

endmodule

// File: rtl/mrxChecker.sv
module mrxChecker #(
  parameter int SPB = 16
) (
  input logic clk,
  input logic rstN,
  input logic bitValid,
  input logic frameStart,
  input logic frameEnd,
  input logic locked
);

  localparam int BLANK = (SPB * 3) / 4;
  localparam int LIMIT = (SPB * 3) / 2;
  localparam int GW    = $clog2(LIMIT + 2);
  localparam logic [GW-1:0] GAP_MAX = GW'(LIMIT + 1);
  localparam logic [GW-1:0] BLANK_V = GW'(BLANK);
  localparam logic [GW-1:0] LIMIT_V = GW'(LIMIT);

  // Samples since the last bit or frame-start strobe.
  logic [GW-1:0] gap;

  always_ff @(posedge clk) begin
    if (!rstN)                      gap <= GAP_MAX;
    else if (bitValid || frameStart) gap <= GW'(1);
    else if (gap != GAP_MAX)        gap <= gap + 1'b1;
  end

  a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $countones({bitValid, frameStart, frameEnd}) <= 1);

  a_r3_bit_spacing: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |-> (gap >= BLANK_V));

  a_r7_end_after_silence: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |-> (gap == LIMIT_V));

  a_r7_end_single: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |=> !frameEnd);

  a_r6_start_needs_lock: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> $past(locked));

  a_r9_bits_while_locked: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |-> locked);

  a_r9_end_drops_lock: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |-> !locked);

endmodule

bind mrxReceiver mrxChecker #(.SPB(SAMPLES_PER_BIT)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .bitValid  (bitValid),
  .frameStart(frameStart),
  .frameEnd  (frameEnd),
  .locked    (locked)
);

// File: tb/mrxReceiver_tb.sv
module mrxReceiver_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineIn = 1'b0;
  logic bitValid, bitData, frameStart, frameEnd, locked;

  int checks = 0;
  int errors = 0;

  bit txBits [0:2047];
  bit rxBits [0:2047];
  int rxCount = 0;
  int startCnt = 0;
  int endCnt = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  mrxReceiver u_dut (
    .clk(clk), .rstN(rstN), .lineIn(lineIn),
    .bitValid(bitValid), .bitData(bitData),
    .frameStart(frameStart), .frameEnd(frameEnd), .locked(locked)
  );

  // Output monitor, sampled away from the active edge.
  always @(negedge clk) begin
    if (rstN) begin
      if (bitValid) begin
        if (rxCount < 2048) rxBits[rxCount] = bitData;
        rxCount++;
      end
      if (frameStart) startCnt++;
      if (frameEnd) endCnt++;
    end
  end

  task automatic checkEq(input string what, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, actual, expected);
    end
  endtask

  task automatic clearMon();
    rxCount = 0; startCnt = 0; endCnt = 0;
  endtask

  task automatic fillPayload(input int n, input int mode);
    for (int i = 0; i < n; i++) begin
      if (mode == 1) txBits[i] = 1'b1;
      else if (mode == 2) txBits[i] = 1'b0;
      else begin
        txBits[i] = lfsr[0];
        lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
      end
    end
  endtask

  task automatic holdLine(input logic level, input int n);
    lineIn = level;
    repeat (n) @(negedge clk);
  endtask

  task automatic driveBit(input bit b, input int h1, input int h2);
    holdLine(!b, h1);
    holdLine(b, h2);
  endtask

  // Preamble of preLen alternating bits from preFirst, optional closing 11,
  // payload, then silence. tailD > 0 stretches the last half-bit to tailD
  // samples and toggles the line once more.
  task automatic sendFrame(input int preLen, input bit preFirst, input bit withSfd,
                           input int n, input int h1, input int h2, input int tailD);
    bit pb;
    holdLine(!preFirst, 40);
    pb = preFirst;
    for (int i = 0; i < preLen; i++) begin
      driveBit(pb, h1, h2);
      pb = !pb;
    end
    if (withSfd) begin
      driveBit(1'b1, h1, h2);
      driveBit(1'b1, h1, h2);
    end
    for (int i = 0; i < n; i++) begin
      if (i == n - 1 && tailD > 0) begin
        holdLine(!txBits[i], h1);
        holdLine(txBits[i], tailD);
        holdLine(!txBits[i], 60);
      end else begin
        driveBit(txBits[i], h1, h2);
      end
    end
    repeat (60) @(negedge clk);
  endtask

  function automatic int countMismatch(input int n);
    int m = 0;
    for (int i = 0; i < n && i < rxCount && i < 2048; i++)
      if (rxBits[i] != txBits[i]) m++;
    return m;
  endfunction

  task automatic testReset();
    rstN = 1'b0;
    repeat (5) @(negedge clk);
    checkEq("R1 bitValid in reset", int'(bitValid), 0);
    checkEq("R1 frameStart in reset", int'(frameStart), 0);
    rstN = 1'b1;
    @(negedge clk);
    checkEq("R1 frameEnd after reset", int'(frameEnd), 0);
    checkEq("R1 locked after reset", int'(locked), 0);
  endtask

  task automatic testFrame(input string tag, input int n, input int mode,
                           input int h1, input int h2);
    fillPayload(n, mode);
    clearMon();
    sendFrame(20, 1'b1, 1'b1, n, h1, h2, 0);
    checkEq({tag, " R6 frame start count"}, startCnt, 1);
    checkEq({tag, " R7 frame end count"}, endCnt, 1);
    checkEq({tag, " R4 bit count"}, rxCount, n);
    checkEq({tag, " R2 bit mismatches"}, countMismatch(n), 0);
    checkEq({tag, " R9 unlocked after end"}, int'(locked), 0);
  endtask

  task automatic testLockBoundary();
    // Run of 16: 15 bits from 0 ending in 0, then the closing 1,1.
    fillPayload(24, 0);
    clearMon();
    sendFrame(15, 1'b0, 1'b1, 24, 8, 8, 0);
    checkEq("R5 run16 frame start", startCnt, 1);
    checkEq("R5 run16 bit count", rxCount, 24);
    checkEq("R5 run16 mismatches", countMismatch(24), 0);
    // Run of 15: 14 bits from 1 ending in 0, then 1,1: no lock.
    fillPayload(24, 2);
    clearMon();
    sendFrame(14, 1'b1, 1'b1, 24, 8, 8, 0);
    checkEq("R5 run15 frame start", startCnt, 0);
    checkEq("R5 run15 bit count", rxCount, 0);
    checkEq("R5 run15 frame end", endCnt, 0);
    checkEq("R5 run15 locked", int'(locked), 0);
  endtask

  task automatic testSilenceEdge();
    fillPayload(32, 0);
    clearMon();
    sendFrame(20, 1'b1, 1'b1, 32, 8, 8, 24);
    checkEq("R7 edge at limit bit count", rxCount, 33);
    checkEq("R7 edge at limit extra bit", int'(rxBits[32]), int'(!txBits[31]));
    checkEq("R7 edge at limit frame end", endCnt, 1);
    fillPayload(32, 0);
    clearMon();
    sendFrame(20, 1'b1, 1'b1, 32, 8, 8, 25);
    checkEq("R7 edge past limit bit count", rxCount, 32);
    checkEq("R7 edge past limit frame end", endCnt, 1);
    checkEq("R7 edge past limit frame start", startCnt, 1);
  endtask

  initial begin
    #(4 * 190000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testFrame("nominal", 64, 0, 8, 8);
    testFrame("ones R3", 48, 1, 8, 8);
    testFrame("zeros R3", 48, 2, 8, 8);
    testFrame("slow17", 1500, 0, 8, 9);
    testFrame("fast15", 1500, 0, 7, 8);
    testLockBoundary();
    testSilenceEdge();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule